// File: doc/BRIEF.md
# Interrupt Source Collector with Enable/Status Register

This block gathers three interrupt requests into one interrupt line for an analog output engine. Two requests are edge-type: an external trigger input and the output of a pacing counter. Both are resynchronised and then latched on their rising edges. The third is a level-type request from the output data FIFO. It is shown live and is never latched.

A single byte-wide register location behaves differently for writes and reads. A write loads the enable mask. A read returns the status vector. Software acknowledges an edge event by writing the mask with that source's bit cleared, which discards the latched event, and then writes the mask again with the bit set. A level request is acknowledged by removing its cause at the FIFO.

The host bus decode and the logic behind each source are outside this block.

Top module: `irq_src_reg`

## Requirements
- R1: After reset the enable mask is zero, every status bit reads 0 and `irq` is low.
- R2: Status bit 0 (external input) is set by a rising edge of `ext_in` while enable bit 0 is set. The edge passes through a two-flop synchronizer, so the bit reads 1 after the third rising clock edge that follows the input change, and still reads 0 after the second.
- R3: Status bit 5 (counter output) behaves like bit 0, with the same three-edge latency from `cnt_out`.
- R4: Status bit 2 is the live value of `fifo_req` ANDed with enable bit 2, with no latching and no added clock latency. It drops as soon as the request drops.
- R5: An edge that arrives while its enable bit is 0 is lost. Setting the enable bit afterwards does not make the status bit read 1.
- R6: Writing 0 to an edge source's enable bit clears its latched status. Writing 1 to that enable bit leaves an already-latched status unchanged.
- R7: `irq` is high exactly when some enabled status bit is 1.
- R8: Writing 0x00 to the register disables all sources: the next read returns 0x00 and `irq` is low.
- R9: Bits 1, 3, 4, 6 and 7 of the read value are always 0, whatever value was written.
- R10: An edge input that stays high does not set its status again after an acknowledge (clear, then re-enable). Only a new rising edge sets it.
- R11: When a write clears an edge source's enable bit in the same cycle that a rising edge of that source is detected, the clear wins and the status stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe that loads the enable mask |
| wr_data | input | 8 | Enable mask value to write |
| rd_data | output | 8 | Status vector (bit 0 external, bit 2 FIFO, bit 5 counter) |
| ext_in | input | 1 | External trigger request, asynchronous, rising-edge |
| fifo_req | input | 1 | FIFO request, synchronous, level |
| cnt_out | input | 1 | Counter output, asynchronous, rising-edge |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the collision between an acknowledge write and a freshly detected edge, because the edge becomes visible only inside the synchronizer pipeline. The bench raises the input on a falling clock edge. It waits two clock edges and then asserts the clearing write so that it lands on the detection cycle. It then re-enables the source and confirms that nothing was latched. A related case holds an input high across a clear-and-restore sequence, to show that a held level is not taken as a new edge.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int REG_W    = 8;
  localparam int EXT_POS  = 0;
  localparam int FIFO_POS = 2;
  localparam int CNT_POS  = 5;
  localparam int N_EDGE   = 2;

  // Bits of the register that carry a real source
  function automatic logic [REG_W-1:0] impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[EXT_POS]  = 1'b1;
    m[FIFO_POS] = 1'b1;
    m[CNT_POS]  = 1'b1;
    return m;
  endfunction

  // Register bit position of edge source i (0: external, 1: counter)
  function automatic int edge_pos(int i);
    return (i == 0) ? EXT_POS : CNT_POS;
  endfunction

  // Interrupt line: any status bit that is also enabled
  function automatic logic irq_merge(logic [REG_W-1:0] stat, logic [REG_W-1:0] en);
    return |(stat & en);
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], d};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic en,
  input  logic clr,
  output logic stat
);
  always_ff @(posedge clk) begin
    if (!rst_n)          stat <= 1'b0;
    else if (clr)        stat <= 1'b0;
    else if (rise && en) stat <= 1'b1;
  end
endmodule

// File: rtl/irq_src_reg.sv
module irq_src_reg
  import irq_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ext_in,
  input  logic             fifo_req,
  input  logic             cnt_out,
  output logic             irq
);
  localparam logic [REG_W-1:0] IMPL = impl_mask();

  logic [REG_W-1:0]  en_q;
  logic [N_EDGE-1:0] edge_in;
  logic [N_EDGE-1:0] edge_stat;
  logic [N_EDGE-1:0] edge_det;
  logic [REG_W-1:0]  edge_rise;
  logic [REG_W-1:0]  status;

  assign edge_in = {cnt_out, ext_in};

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data & IMPL;
  end

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    localparam int P = edge_pos(g);
    logic clr_w;
    assign clr_w = wr_en & ~wr_data[P];

    irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(edge_in[g]), .rise(edge_det[g])
    );
    irq_edge_latch u_latch (
      .clk(clk), .rst_n(rst_n), .rise(edge_det[g]), .en(en_q[P]),
      .clr(clr_w), .stat(edge_stat[g])
    );
  end

  always_comb begin
    status    = '0;
    edge_rise = '0;
    for (int i = 0; i < N_EDGE; i++) begin
      status[edge_pos(i)]    = edge_stat[i];
      edge_rise[edge_pos(i)] = edge_det[i];
    end
    status[FIFO_POS] = fifo_req & en_q[FIFO_POS];
  end

  assign rd_data = status;
  assign irq     = irq_merge(status, en_q);
endmodule

// File: rtl/irq_src_reg_chk.sv
module irq_src_reg_chk
  import irq_src_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             fifo_req,
  input logic             irq,
  input logic [REG_W-1:0] en_q,
  input logic [REG_W-1:0] edge_rise
);
  localparam logic [REG_W-1:0] IMPL = impl_mask();

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_data == '0 && !irq));

  p_ext_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_rise[EXT_POS] && en_q[EXT_POS] && !(wr_en && !wr_data[EXT_POS])) |=> rd_data[EXT_POS]);

  p_cnt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_rise[CNT_POS] && en_q[CNT_POS] && !(wr_en && !wr_data[CNT_POS])) |=> rd_data[CNT_POS]);

  p_level_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[FIFO_POS] |-> fifo_req);

  p_edge_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[EXT_POS]) |-> $past(en_q[EXT_POS]));

  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CNT_POS]) |=> !rd_data[CNT_POS]);

  p_irq_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data != '0));

  p_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == '0) |=> (!irq && rd_data == '0));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~IMPL) == '0);

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[EXT_POS] && edge_rise[EXT_POS]) |=> !rd_data[EXT_POS]);
endmodule

bind irq_src_reg irq_src_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .fifo_req(fifo_req), .irq(irq),
  .en_q(en_q), .edge_rise(edge_rise)
);

// File: tb/irq_src_reg_test.sv
module irq_src_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ext_in = 1'b0;
  logic       fifo_req = 1'b0;
  logic       cnt_out = 1'b0;
  logic       irq;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_src_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ext_in(ext_in), .fifo_req(fifo_req),
    .cnt_out(cnt_out), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // write mask; returns at the falling edge after the register has loaded
  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 status", rd_data, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ext_edge;
    wr(8'h21);
    ext_in = 1'b1;
    idle(2);
    chk("R2 not yet after 2 edges", rd_data, 8'h00);
    idle(1);
    chk("R2 latched after 3 edges", rd_data, 8'h01);
    chk("R7 irq from ext", {7'b0, irq}, 8'h01);
    ext_in = 1'b0;
    wr(8'h20);
    chk("R6 clear ext", rd_data, 8'h00);
    idle(3);
  endtask

  task automatic t_cnt_edge;
    wr(8'h20);
    cnt_out = 1'b1;
    idle(2);
    chk("R3 not yet after 2 edges", rd_data, 8'h00);
    idle(1);
    chk("R3 latched after 3 edges", rd_data, 8'h20);
    wr(8'h25);
    chk("R6 enable write keeps status", rd_data, 8'h20);
    cnt_out = 1'b0;
    wr(8'h00);
    chk("R8 zero write status", rd_data, 8'h00);
    chk("R8 zero write irq", {7'b0, irq}, 8'h00);
    idle(3);
  endtask

  task automatic t_level;
    wr(8'h04);
    chk("R4 no request", rd_data, 8'h00);
    @(negedge clk); fifo_req = 1'b1; #1;
    chk("R4 live request", rd_data, 8'h04);
    chk("R7 irq from level", {7'b0, irq}, 8'h01);
    @(negedge clk); fifo_req = 1'b0; #1;
    chk("R4 request dropped", rd_data, 8'h00);
    fifo_req = 1'b1;
    wr(8'h00);
    chk("R4 request masked", rd_data, 8'h00);
    chk("R7 masked irq", {7'b0, irq}, 8'h00);
    fifo_req = 1'b0;
  endtask

  task automatic t_disabled_edge;
    wr(8'h00);
    cnt_out = 1'b1;
    idle(4);
    wr(8'h20);
    idle(2);
    chk("R5 edge while disabled lost", rd_data, 8'h00);
    cnt_out = 1'b0;
    idle(3);
  endtask

  task automatic t_held_ack;
    wr(8'h01);
    ext_in = 1'b1;
    idle(3);
    chk("R10 first edge latched", rd_data, 8'h01);
    wr(8'h00);
    wr(8'h01);
    idle(3);
    chk("R10 held level no relatch", rd_data, 8'h00);
    ext_in = 1'b0;
    idle(3);
    ext_in = 1'b1;
    idle(3);
    chk("R10 new edge latched", rd_data, 8'h01);
    ext_in = 1'b0;
    wr(8'h00);
    idle(3);
  endtask

  task automatic t_unused;
    fifo_req = 1'b1;
    wr(8'hDA);
    ext_in = 1'b1; cnt_out = 1'b1;
    idle(4);
    chk("R9 unused bits only", rd_data, 8'h00);
    chk("R9 irq idle", {7'b0, irq}, 8'h00);
    ext_in = 1'b0; cnt_out = 1'b0;
    wr(8'hFF);
    idle(3);
    ext_in = 1'b1; cnt_out = 1'b1;
    idle(3);
    chk("R9 all sources", rd_data, 8'h25);
    ext_in = 1'b0; cnt_out = 1'b0; fifo_req = 1'b0;
    wr(8'h00);
    idle(3);
  endtask

  task automatic t_collide;
    wr(8'h01);
    ext_in = 1'b1;
    idle(2);
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    chk("R11 clear wins over edge", rd_data, 8'h00);
    wr(8'h01);
    chk("R11 nothing latched", rd_data, 8'h00);
    ext_in = 1'b0;
    wr(8'h00);
    idle(3);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_ext_edge();
    t_cnt_edge();
    t_level();
    t_disabled_edge();
    t_held_ack();
    t_unused();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule